// File: doc/BRIEF.md
# TLB Shootdown Launch Sequencer

This block turns one invalidate request into the register traffic that makes a remote translation unit drop cached translations. A request carries a process ID, a virtual address and a page size in bytes. An address of zero means every address for that process. The block talks to the remote unit over a simple 64-bit register port. Each transfer is a valid/ready handshake with a register select and a write flag. On a read, the data is returned in the cycle the handshake completes.

For a targeted invalidate, the block first writes the abbreviated-address register. It then writes a launch word that holds the scope, page-size code and process ID. Writing that word starts the invalidate in the remote unit. After that, the block reads the status register until its top bit reads zero, or until a programmable cycle budget runs out. It ends the operation with a one-cycle done pulse or a one-cycle timeout pulse. While an operation is in flight, the request port is held not-ready. If the register window enable is low, requests are dropped.

Top module: `tlbi_launch_seq`

## Requirements
- R1: While reset is applied and after it is released, the block is idle: req_ready_o=1, bus_valid_o=0, done_o=0, timeout_o=0.
- R2: For a nonzero address, the first bus transfer is a write with select 0 whose data is the address shifted right by 12. For a zero address, no select-0 write happens and the first transfer is the launch write. The select, write flag and data stay stable while a transfer waits for bus_ready_i.
- R3: The launch transfer is a write with select 1. In its data, bit 0 is 1, bits 2:1 are 2'b10, bit 6 is 1, bits 29:10 hold the process ID, and bits 63:30 are 0.
- R4: In the launch data, a nonzero address gives bits 4:3 = 2'b00 and bit 5 = 0. A zero address gives bits 4:3 = 2'b01 and bit 5 = 1.
- R5: Launch bits 9:7 hold the page-size code: 3'b000 for 0x1000, 3'b001 for 0x200000, 3'b010 for 0x40000000, and 3'b101 for any other size (0x10000 included).
- R6: After the launch, every transfer is a read with select 2. The first read whose bit 63 is 0 ends the operation. done_o is then 1 for exactly one cycle, and no further transfer follows.
- R7: The cycle budget tmo_cycles_i is sampled when the launch write completes. If bus_ready_i stays high and bit 63 stays 1, exactly tmo_cycles_i+1 status reads are made. timeout_o then pulses for one cycle, and done_o stays 0.
- R8: While win_en_i is 0, a request has no effect: no bus transfer, no done or timeout pulse, and req_ready_o stays 1.
- R9: req_ready_o is 0 from the cycle after acceptance until the cycle in which done_o or timeout_o is 1. While req_ready_o is 1, bus_valid_o is 0.
- R10: done_o and timeout_o are never 1 together, and neither is 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_en_i | input | 1 | Register window enabled |
| tmo_cycles_i | input | TMO_W | Poll budget in cycles |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_pid_i | input | PID_W | Process ID |
| req_addr_i | input | 64 | Virtual address, 0 = all |
| req_psize_i | input | PS_W | Page size in bytes |
| bus_valid_o | output | 1 | Register transfer valid |
| bus_ready_i | input | 1 | Register transfer accepted |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_sel_o | output | 2 | 0 address, 1 launch, 2 status |
| bus_wdata_o | output | 64 | Write data |
| bus_rdata_i | input | 64 | Read data, valid with the read handshake |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Timeout pulse |

## Verification
The exact length of the timeout window is the hardest thing to observe. It shows only when the remote unit keeps its pending bit set and accepts every read at once, so that the poll count equals the budget plus one. The bench's remote-unit model has a mode that holds bus_ready_i high and leaves the pending bit set forever. Directed runs in this mode use budgets of 0 and 3. Seeded random runs then mix random ready gaps, addresses, page sizes and pending lengths, so that they reach the done path under back-pressure.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;
  localparam int WORD_W = 64;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_AVA, ST_LNCH, ST_POLL} st_e;

  localparam logic [SEL_W-1:0] SEL_AVA  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LNCH = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;

  // launch word layout
  localparam int B_R    = 0;
  localparam int B_RIC  = 1;
  localparam int B_IS   = 3;
  localparam int B_SNGL = 5;
  localparam int B_PRS  = 6;
  localparam int B_AP   = 7;
  localparam int B_PID  = 10;

  localparam logic [2:0] AP_4K    = 3'b000;
  localparam logic [2:0] AP_2M    = 3'b001;
  localparam logic [2:0] AP_1G    = 3'b010;
  localparam logic [2:0] AP_OTHER = 3'b101;

  localparam int PG_SHIFT = 12;
endpackage

// File: rtl/tlbi_psize_enc.sv
module tlbi_psize_enc #(
  parameter int PS_W = 32
) (
  input  logic [PS_W-1:0] psize_i,
  output logic [2:0]      ap_o
);
  import tlbi_pkg::*;
  localparam logic [PS_W-1:0] SZ_4K = PS_W'(1) << 12;
  localparam logic [PS_W-1:0] SZ_2M = PS_W'(1) << 21;
  localparam logic [PS_W-1:0] SZ_1G = PS_W'(1) << 30;

  always_comb begin
    if (psize_i == SZ_4K)      ap_o = AP_4K;
    else if (psize_i == SZ_2M) ap_o = AP_2M;
    else if (psize_i == SZ_1G) ap_o = AP_1G;
    else                       ap_o = AP_OTHER;
  end
endmodule

// File: rtl/tlbi_word_enc.sv
module tlbi_word_enc #(
  parameter int PID_W = 20
) (
  input  logic [PID_W-1:0]             pid_i,
  input  logic                         full_i,
  input  logic [2:0]                   ap_i,
  output logic [tlbi_pkg::WORD_W-1:0]  word_o
);
  import tlbi_pkg::*;
  always_comb begin
    word_o               = '0;
    word_o[B_R]          = 1'b1;
    word_o[B_RIC +: 2]   = 2'b10;
    word_o[B_IS +: 2]    = full_i ? 2'b01 : 2'b00;
    word_o[B_SNGL]       = full_i;
    word_o[B_PRS]        = 1'b1;
    word_o[B_AP +: 3]    = ap_i;
    word_o[B_PID +: PID_W] = pid_i;
  end
endmodule

// File: rtl/tlbi_tmo_ctr.sv
module tlbi_tmo_ctr #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMO_W-1:0] val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tlbi_launch_seq.sv
module tlbi_launch_seq #(
  parameter int PID_W = 20,
  parameter int PS_W  = 32,
  parameter int TMO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_en_i,
  input  logic [TMO_W-1:0]  tmo_cycles_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [63:0]       req_addr_i,
  input  logic [PS_W-1:0]   req_psize_i,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic              bus_write_o,
  output logic [1:0]        bus_sel_o,
  output logic [63:0]       bus_wdata_o,
  input  logic [63:0]       bus_rdata_i,
  output logic              done_o,
  output logic              timeout_o
);
  import tlbi_pkg::*;
  localparam int AVA_W = 64 - PG_SHIFT;

  st_e              st_q;
  logic [PID_W-1:0] pid_q;
  logic [AVA_W-1:0] ava_q;
  logic             full_q;
  logic [2:0]       ap_q;
  logic             done_q, tmo_q;
  logic [2:0]       ap_d;
  logic [63:0]      lnch_word;
  logic             expired;
  logic             lnch_fire;
  logic             unused_rd;

  assign unused_rd = ^bus_rdata_i[62:0];

  tlbi_psize_enc #(.PS_W(PS_W)) u_ps (.psize_i(req_psize_i), .ap_o(ap_d));

  tlbi_word_enc #(.PID_W(PID_W)) u_we (
    .pid_i(pid_q), .full_i(full_q), .ap_i(ap_q), .word_o(lnch_word)
  );

  assign lnch_fire = (st_q == ST_LNCH) && bus_ready_i;

  tlbi_tmo_ctr #(.TMO_W(TMO_W)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lnch_fire), .val_i(tmo_cycles_i),
    .run_i(st_q == ST_POLL), .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pid_q  <= '0;
      ava_q  <= '0;
      full_q <= 1'b0;
      ap_q   <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i && win_en_i) begin
          pid_q  <= req_pid_i;
          ava_q  <= req_addr_i[63:PG_SHIFT];
          full_q <= (req_addr_i == '0);
          ap_q   <= ap_d;
          st_q   <= (req_addr_i != '0) ? ST_AVA : ST_LNCH;
        end
        ST_AVA:  if (bus_ready_i) st_q <= ST_LNCH;
        ST_LNCH: if (bus_ready_i) st_q <= ST_POLL;
        ST_POLL: if (bus_ready_i) begin
          if (!bus_rdata_i[63]) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (expired) begin
            tmo_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign bus_valid_o = (st_q != ST_IDLE);
  assign bus_write_o = (st_q != ST_POLL);
  always_comb begin
    unique case (st_q)
      ST_AVA:  bus_sel_o = SEL_AVA;
      ST_LNCH: bus_sel_o = SEL_LNCH;
      default: bus_sel_o = SEL_STAT;
    endcase
  end
  assign bus_wdata_o = (st_q == ST_AVA) ? {{PG_SHIFT{1'b0}}, ava_q} :
                       (st_q == ST_LNCH) ? lnch_word : '0;
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/tlbi_launch_seq_chk.sv
module tlbi_launch_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        win_en_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        bus_valid_o,
  input logic        bus_ready_i,
  input logic        bus_write_o,
  input logic [1:0]  bus_sel_o,
  input logic [63:0] bus_wdata_o,
  input logic        done_o,
  input logic        timeout_o
);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_valid_o);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_tmo_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_sel_o) && $stable(bus_write_o) && $stable(bus_wdata_o)));

  p_launch_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_write_o && bus_sel_o == 2'd1) |->
      (bus_wdata_o[0] && bus_wdata_o[2:1] == 2'b10 && bus_wdata_o[6]));

  p_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && !win_en_i) |=> req_ready_o);
endmodule

bind tlbi_launch_seq tlbi_launch_seq_chk u_chk (.*);

// File: tb/tlbi_launch_seq_bench.sv
module tlbi_launch_seq_bench;
  localparam int PID_W = 20;
  localparam int PS_W  = 32;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_en = 1'b1;
  logic [TMO_W-1:0] tmo_cycles = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [PID_W-1:0] req_pid = '0;
  logic [63:0] req_addr = '0;
  logic [PS_W-1:0] req_psize = '0;
  logic bus_valid, bus_ready, bus_write;
  logic [1:0] bus_sel;
  logic [63:0] bus_wdata, bus_rdata;
  logic done, tmo;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  tlbi_launch_seq #(.PID_W(PID_W), .PS_W(PS_W), .TMO_W(TMO_W)) u_tlbi_launch_seq (
    .clk_i(clk), .rst_ni(rst_n), .win_en_i(win_en), .tmo_cycles_i(tmo_cycles),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_pid_i(req_pid),
    .req_addr_i(req_addr), .req_psize_i(req_psize),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready), .bus_write_o(bus_write),
    .bus_sel_o(bus_sel), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .done_o(done), .timeout_o(tmo)
  );

  // remote translation unit model
  logic [1:0]  log_sel  [0:255];
  logic        log_wr   [0:255];
  logic [63:0] log_data [0:255];
  int  log_n = 0;
  int  polls_left = 0;
  bit  rdy_always = 1'b1;

  initial begin bus_ready = 1'b0; bus_rdata = '0; end

  always @(negedge clk) begin
    automatic logic r = rdy_always ? 1'b1 : ($urandom % 3 != 0);
    bus_ready = r;
    bus_rdata = {(polls_left > 0), 63'h0};
    if (bus_valid && r) begin
      if (log_n < 256) begin
        log_sel[log_n] = bus_sel; log_wr[log_n] = bus_write; log_data[log_n] = bus_wdata;
      end
      log_n++;
      if (!bus_write && polls_left > 0 && polls_left < 100000) polls_left--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_ap(input logic [PS_W-1:0] ps);
    if (ps == 32'h1000)          return 3'b000;
    else if (ps == 32'h200000)   return 3'b001;
    else if (ps == 32'h40000000) return 3'b010;
    return 3'b101;
  endfunction

  function automatic logic [63:0] exp_word(input logic [PID_W-1:0] pid, input logic [63:0] a,
                                           input logic [PS_W-1:0] ps);
    logic [63:0] w = '0;
    w[29:10] = pid;
    w[9:7]   = exp_ap(ps);
    w[6]     = 1'b1;
    w[5]     = (a == 0);
    w[4:3]   = (a == 0) ? 2'b01 : 2'b00;
    w[2:1]   = 2'b10;
    w[0]     = 1'b1;
    return w;
  endfunction

  task automatic run_req(input logic [PID_W-1:0] pid, input logic [63:0] a,
                         input logic [PS_W-1:0] ps, input int npoll, input int budget,
                         input bit ra, input bit exp_to);
    int idx, reads, wait_c;
    bit busy_bad, d, t;
    log_n = 0; polls_left = npoll; rdy_always = ra; tmo_cycles = TMO_W'(budget);
    @(negedge clk);
    req_pid = pid; req_addr = a; req_psize = ps; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 0; wait_c = 0;
    while (!done && !tmo && wait_c < 5000) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk); wait_c++;
    end
    chk(!busy_bad, "R9 ready low while busy", busy_bad, 0);
    d = done; t = tmo;
    chk(req_ready, "R9 ready back at report", req_ready, 1);
    @(negedge clk);
    chk(!done && !tmo, "R10 single-cycle pulse", {done, tmo}, 0);
    idx = 0;
    if (a != 0) begin
      chk(log_sel[0] == 2'd0 && log_wr[0], "R2 address write first", log_sel[0], 0);
      chk(log_data[0] == (a >> 12), "R2 address data", log_data[0], a >> 12);
      idx = 1;
    end
    chk(log_sel[idx] == 2'd1 && log_wr[idx], "R2 launch follows", log_sel[idx], 1);
    chk(log_data[idx] == exp_word(pid, a, ps), "R3 R4 R5 launch word",
        log_data[idx], exp_word(pid, a, ps));
    reads = 0;
    for (int k = idx + 1; k < log_n && k < 256; k++) begin
      if (log_sel[k] == 2'd2 && !log_wr[k]) reads++;
    end
    chk(reads == log_n - idx - 1, "R6 only status reads after launch", reads, log_n - idx - 1);
    if (exp_to) begin
      chk(t && !d, "R7 timeout reported", {d, t}, 2'b01);
      if (ra) chk(reads == budget + 1, "R7 poll count", reads, budget + 1);
    end else begin
      chk(d && !t, "R6 done reported", {d, t}, 2'b10);
      chk(reads == npoll + 1, "R6 poll count", reads, npoll + 1);
    end
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL watchdog act=%0d exp<%0d", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk(req_ready && !bus_valid && !done && !tmo, "R1 in reset", {req_ready, bus_valid, done, tmo}, 4'b1000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !done && !tmo, "R1 after reset", {req_ready, bus_valid, done, tmo}, 4'b1000);

    // R8: window disabled
    win_en = 1'b0; log_n = 0;
    req_valid = 1'b1; req_addr = 64'h1234_5000; req_psize = 32'h1000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req_ready && !done && !tmo, "R8 ignored no state change", {req_ready, done, tmo}, 3'b100);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(log_n == 0, "R8 no bus traffic", log_n, 0);
    win_en = 1'b1;

    // directed corners
    run_req(20'hABCDE, 64'h0000_7FFF_1234_5000, 32'h1000,     2, 1000, 1, 0); // R2 R5 4K
    run_req(20'h00001, 64'h0,                   32'h200000,   0, 1000, 1, 0); // R4 full
    run_req(20'hFFFFF, 64'hFFFF_FFFF_FFFF_F000, 32'h40000000, 1, 1000, 0, 0); // R5 1G
    run_req(20'h12345, 64'h0,                   32'h10000,    3, 1000, 0, 0); // R5 64K
    run_req(20'h00042, 64'h1000,                32'h2000,     0, 1000, 1, 0); // R5 other
    run_req(20'h00777, 64'h8000,                32'h1000, 100000, 3, 1, 1);   // R7
    run_req(20'h00778, 64'h0,                   32'h1000, 100000, 0, 1, 1);   // R7 zero budget
    run_req(20'h00779, 64'h9000,                32'h1000, 100000, 5, 0, 1);   // R7 back-pressure

    // random mix
    for (int n = 0; n < 40; n++) begin
      automatic logic [PID_W-1:0] p = PID_W'($urandom);
      automatic logic [63:0] a = ($urandom % 3 == 0) ? 64'h0 : {$urandom, $urandom};
      automatic int sel = $urandom % 5;
      automatic logic [PS_W-1:0] ps = (sel == 0) ? 32'h1000 : (sel == 1) ? 32'h200000 :
                                      (sel == 2) ? 32'h40000000 : (sel == 3) ? 32'h10000 : $urandom;
      run_req(p, a, ps, $urandom % 6, 1000, $urandom % 2, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule